// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a memory-mapped system watchdog. Software arms it once after power-on by writing a control word. The word holds a 16-bit timeout count, an enable flag, a choice between a reset request and an interrupt on expiry, and a prescale switch. Once the block is armed, a down-counter runs. The only way to restart it is an ordered pair of key writes to the service register. If software stops servicing, the counter reaches the end of its period and the block either pulses a reset request to the reset controller or raises a sticky interrupt.

The control register accepts exactly one write after reset. That write decides whether the watchdog is armed or left off for good, and no later write can change either the enable state or the other fields. The count register reads back the live counter. Two parameters select variants. One sets the prescale length (65536 or 2048 input clocks per tick). The other makes the watchdog come out of reset already armed, with its control register locked.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, with the boot-armed variant off, the control word reads 0xFFFF0003, the count register reads 0xFFFF, and both `wdt_rst_req` and `wdt_irq` are low.
- R2: The control word at byte offset 0x4 holds the timeout in bits 31:16, enable in bit 2, mode select in bit 1 (1 = reset request, 0 = interrupt) and prescale enable in bit 0. It reads back exactly as written, with bits 15:3 reading zero. The count register sits at offset 0x8.
- R3: Only the first control write after reset is accepted. Later writes change neither the fields nor the enable state, in either direction.
- R4: A timeout field of zero is stored and used as 1.
- R5: With prescale off, the counter is loaded with the timeout when the enabling write lands and drops by one every clock. The count register shows the live value.
- R6: With prescale on, the counter drops once every `PRESCALE_CLKS` clocks. A timeout of N therefore expires N × `PRESCALE_CLKS` clocks after the last load.
- R7: Writing 0x556C and then 0xAA39 to the service register (offset 0xC or 0xE, data in bits 15:0) reloads the counter from the timeout and clears any partial prescale period.
- R8: After a 0x556C, any other value returns the key checker to idle without a service. A repeated 0x556C keeps it waiting for 0xAA39. A lone 0xAA39 does nothing.
- R9: In reset mode, expiry gives a one-clock pulse on `wdt_rst_req` and leaves `wdt_irq` low.
- R10: In interrupt mode, expiry sets `wdt_irq`, which stays high until the next valid key pair.
- R11: At expiry the counter reloads from the timeout and keeps running, so expiry repeats every period until a service arrives.
- R12: When the first control write leaves the watchdog disabled, the counter holds the timeout value and no expiry ever occurs.
- R13: With `BOOT_ARMED` = 1, the block leaves reset enabled with the control word reading 0xFFFF0007, and every control write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address within the 0x100 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | One-cycle system reset request on expiry |
| wdt_irq | output | 1 | Sticky expiry interrupt |

## Verification
The counter is driven with prescale off and short timeouts. This shows the per-clock decrement, the exact expiry cycle, the reload at expiry and the one-cycle reset pulse apart from the sticky interrupt. A prescaled run, and a service sent in the middle of a prescale period, show the tick spacing and separate a cleared prescaler remainder from a retained one. Key patterns cover a wrong second word, a doubled first key and a lone second key. Each is judged by whether the live count jumped back to the timeout. Repeated control writes, and a separately configured boot-armed instance, check the write-once lock from both the disabled and the armed starting state.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int CNT_W = 16;
  localparam logic [15:0] KEY_FIRST  = 16'h556C;
  localparam logic [15:0] KEY_SECOND = 16'hAA39;
  localparam logic [5:0]  WORD_CTRL  = 6'd1;   // byte 0x4
  localparam logic [5:0]  WORD_COUNT = 6'd2;   // byte 0x8
  localparam logic [5:0]  WORD_SVC   = 6'd3;   // bytes 0xC..0xF

  typedef struct packed {
    logic [CNT_W-1:0] limit;
    logic             arm;
    logic             to_reset;
    logic             slow;
  } wdk_cfg_t;

  typedef enum logic {KEY_IDLE, KEY_HALF} key_st_t;

  function automatic logic [31:0] pack_ctrl(input wdk_cfg_t c);
    return {c.limit, 13'd0, c.arm, c.to_reset, c.slow};
  endfunction

  function automatic wdk_cfg_t unpack_ctrl(input logic [31:0] w);
    wdk_cfg_t c;
    c.limit    = (w[31:16] == '0) ? CNT_W'(1) : w[31:16];
    c.arm      = w[2];
    c.to_reset = w[1];
    c.slow     = w[0];
    return c;
  endfunction
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter bit BOOT_ARMED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  output wdk_cfg_t    cfg,
  output logic        locked,
  output logic        ctrl_load
);
  localparam wdk_cfg_t CFG_RST = '{limit: '1, arm: BOOT_ARMED, to_reset: 1'b1, slow: 1'b1};

  assign ctrl_load = ctrl_wr && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RST;
      locked <= BOOT_ARMED;
    end else if (ctrl_load) begin
      cfg    <= unpack_ctrl(ctrl_wdata);
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key_data,
  output logic        service,
  output logic        armed
);
  key_st_t st_q, st_d;

  always_comb begin
    st_d    = st_q;
    service = 1'b0;
    if (key_wr) begin
      if (key_data == KEY_FIRST) begin
        st_d = KEY_HALF;
      end else if (st_q == KEY_HALF && key_data == KEY_SECOND) begin
        st_d    = KEY_IDLE;
        service = 1'b1;
      end else begin
        st_d = KEY_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == KEY_HALF);
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer
  import wdk_pkg::*;
#(
  parameter int PRESCALE_CLKS = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             slow,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int PRE_W = (PRESCALE_CLKS > 1) ? $clog2(PRESCALE_CLKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_CLKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic             pre_wrap;
  logic             tick;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign tick     = enable && (!slow || pre_wrap);
  assign expire   = tick && (count == CNT_W'(1)) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '1;
    end else if (reload) begin
      pre_q <= '0;
      count <= reload_val;
    end else if (enable) begin
      if (slow) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (tick) count <= (count == CNT_W'(1)) ? reload_val : count - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int PRESCALE_CLKS = 65536,
  parameter bit BOOT_ARMED    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_req,
  output logic        wdt_irq
);
  wdk_cfg_t         cfg_q;
  logic             cfg_locked;
  logic             ctrl_load;
  logic             ctrl_sel, svc_sel;
  logic             svc_evt, key_armed;
  logic             exp_evt;
  logic [CNT_W-1:0] live_count;
  logic [CNT_W-1:0] reload_val;
  logic [31:0]      ctrl_word;
  logic             cfg_en_w, cfg_rst_w;
  wdk_cfg_t         new_cfg;

  assign ctrl_sel  = bus_wr && (bus_addr[7:2] == WORD_CTRL);
  assign svc_sel   = bus_wr && (bus_addr[7:2] == WORD_SVC);
  assign new_cfg   = unpack_ctrl(bus_wdata);
  assign ctrl_word = pack_ctrl(cfg_q);
  assign cfg_en_w  = cfg_q.arm;
  assign cfg_rst_w = cfg_q.to_reset;

  wdk_regs #(.BOOT_ARMED(BOOT_ARMED)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_sel), .ctrl_wdata(bus_wdata),
    .cfg(cfg_q), .locked(cfg_locked), .ctrl_load(ctrl_load)
  );

  wdk_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .key_wr(svc_sel), .key_data(bus_wdata[15:0]),
    .service(svc_evt), .armed(key_armed)
  );

  assign reload_val = ctrl_load ? new_cfg.limit : cfg_q.limit;

  wdk_timer #(.PRESCALE_CLKS(PRESCALE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(cfg_q.arm), .slow(cfg_q.slow),
    .reload(ctrl_load || svc_evt), .reload_val(reload_val),
    .count(live_count), .expire(exp_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_rst_req <= 1'b0;
      wdt_irq     <= 1'b0;
    end else begin
      wdt_rst_req <= exp_evt && cfg_q.to_reset;
      if (svc_evt)                         wdt_irq <= 1'b0;
      else if (exp_evt && !cfg_q.to_reset) wdt_irq <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr[7:2])
      WORD_CTRL:  bus_rdata = ctrl_word;
      WORD_COUNT: bus_rdata = {{(32-CNT_W){1'b0}}, live_count};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdk_chk.sv
module wdk_chk #(
  parameter bit BOOT_ARMED = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_req,
  input logic        irq,
  input logic        svc,
  input logic        expire,
  input logic        cfg_en,
  input logic        cfg_rst,
  input logic        locked,
  input logic [31:0] cfg_word,
  input logic [15:0] count,
  input logic [15:0] limit,
  input logic        key_armed
);
  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R9
  rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(cfg_rst) && !$rose(irq));
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_word));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (count == limit) && !expire);
  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !svc) |=> irq);
  // R7
  svc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (count == $past(limit)) && !irq);
  // R8
  key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !key_armed);
  // R11
  exp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(limit));
  // R13
  boot_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    BOOT_ARMED |-> cfg_en && locked);
endmodule

bind wdog_keyed wdk_chk #(.BOOT_ARMED(BOOT_ARMED)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(wdt_rst_req), .irq(wdt_irq),
  .svc(svc_evt), .expire(exp_evt), .cfg_en(cfg_en_w), .cfg_rst(cfg_rst_w),
  .locked(cfg_locked), .cfg_word(ctrl_word), .count(live_count),
  .limit(cfg_q.limit), .key_armed(key_armed)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/100ps
module wdog_keyed_test;
  localparam int DIV = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, wr_b = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_b;
  logic        wdt_rst_req, wdt_irq, rst_req_b, irq_b;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_keyed #(.PRESCALE_CLKS(DIV), .BOOT_ARMED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq));

  wdog_keyed #(.PRESCALE_CLKS(DIV), .BOOT_ARMED(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .wdt_rst_req(rst_req_b), .wdt_irq(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic svc_pair();
    wr(8'h0E, 32'h0000_556C);
    wr(8'h0E, 32'h0000_AA39);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h04, d); chk("R1 ctrl reset", d, 32'hFFFF_0003);
    rd(8'h08, d); chk("R1 count reset", d, 32'h0000_FFFF);
    chk("R1 rst_req low", wdt_rst_req, 1'b0);
    chk("R1 irq low", wdt_irq, 1'b0);
  endtask

  task automatic t_once();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0123_0000);
    rd(8'h04, d); chk("R2 readback", d, 32'h0123_0000);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R3 second write ignored", d, 32'h0123_0000);
    tick(20);
    rd(8'h08, d); chk("R12 disabled count holds", d, 32'h0000_0123);
    chk("R12 no irq", wdt_irq, 1'b0);
    chk("R12 no reset", wdt_rst_req, 1'b0);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, d); chk("R4 zero stored as one", d, 32'h0001_0004);
    tick(1);
    chk("R4 one-tick expiry irq", wdt_irq, 1'b1);
  endtask

  task automatic t_count();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0005_0006);
    rd(8'h08, d); chk("R5 loaded", d, 32'd5);
    tick(2);
    rd(8'h08, d); chk("R5 live decrement", d, 32'd3);
    chk("R9 no early pulse", wdt_rst_req, 1'b0);
    tick(3);
    chk("R9 reset pulse", wdt_rst_req, 1'b1);
    rd(8'h08, d); chk("R11 reload at expiry", d, 32'd5);
    tick(1);
    chk("R9 pulse one cycle", wdt_rst_req, 1'b0);
    rd(8'h08, d); chk("R11 keeps running", d, 32'd4);
    chk("R9 irq stays low", wdt_irq, 1'b0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0003_0005);
    tick(DIV - 1);
    rd(8'h08, d); chk("R6 no tick before period", d, 32'd3);
    tick(1);
    rd(8'h08, d); chk("R6 tick at period", d, 32'd2);
    tick(2 * DIV - 1);
    rd(8'h08, d); chk("R6 count before expiry", d, 32'd1);
    chk("R6 irq not yet", wdt_irq, 1'b0);
    tick(1);
    chk("R6 expiry at N*DIV", wdt_irq, 1'b1);
  endtask

  task automatic t_service();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0008_0004);
    tick(3);
    svc_pair();
    rd(8'h08, d); chk("R7 reload on key pair", d, 32'd8);
    tick(7);
    chk("R10 irq before expiry", wdt_irq, 1'b0);
    tick(1);
    chk("R10 irq set", wdt_irq, 1'b1);
    tick(5);
    chk("R10 irq sticky", wdt_irq, 1'b1);
    svc_pair();
    chk("R10 irq cleared by service", wdt_irq, 1'b0);
  endtask

  task automatic t_remainder();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0002_0005);
    tick(1000);
    svc_pair();
    tick(2 * DIV - 1);
    rd(8'h08, d); chk("R7 prescale remainder cleared", d, 32'd1);
    chk("R7 no early expiry", wdt_irq, 1'b0);
    tick(1);
    chk("R7 expiry full period after service", wdt_irq, 1'b1);
  endtask

  task automatic t_badkey();
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0010_0006);
    tick(2);
    wr(8'h0C, 32'h0000_556C);
    wr(8'h0C, 32'h0000_1234);
    wr(8'h0C, 32'h0000_AA39);
    rd(8'h08, d); chk("R8 wrong second word", d, 32'd11);
    wr(8'h0C, 32'h0000_556C);
    wr(8'h0C, 32'h0000_556C);
    wr(8'h0C, 32'h0000_AA39);
    rd(8'h08, d); chk("R8 repeated first key", d, 32'd16);
    wr(8'h0C, 32'h0000_AA39);
    rd(8'h08, d); chk("R8 lone second key", d, 32'd15);
  endtask

  task automatic t_boot();
    logic [31:0] d;
    do_reset();
    bus_addr = 8'h04; #0.2; d = rdata_b;
    chk("R13 armed from reset", d, 32'hFFFF_0007);
    bus_wdata = 32'h0001_0000; wr_b = 1'b1;
    tick(1);
    wr_b = 1'b0;
    bus_addr = 8'h04; #0.2; d = rdata_b;
    chk("R13 control write ignored", d, 32'hFFFF_0007);
    chk("R13 no reset request", rst_req_b, 1'b0);
  endtask

  initial begin
    t_reset();
    t_once();
    t_zero();
    t_count();
    t_prescale();
    t_service();
    t_remainder();
    t_badkey();
    t_boot();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL run-time limit actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule